// File: doc/BRIEF.md
# Synchronous Burst Memory Cycle Controller

This block sits in front of a single-ported synchronous burst memory and turns the raw control pins seen on each rising clock edge into one decided cycle. It looks at three chip enables, a processor-side address strobe, a controller-side address strobe, a burst-advance input, a sleep input and the write-qualifying pins (global write, byte-write enable and one enable per byte lane). From these it classifies the cycle and picks where the array address comes from. The cycle classes are deselect, sleep, burst-start read or write, burst-continue read or write, and burst-suspend read or write. The address can come from nowhere, from the external bus, from the next burst step or from the current held value.

The block holds the upper address bits and a 2-bit burst counter that wraps inside a four-word group. It produces per-lane write enables for the array and the enable for the data-bus output drivers. All decisions are registered on the clock edge. The output-driver enable also follows the output-enable pin and the sleep pin without waiting for a clock. A decoded cycle-type output lets an observer see each decision directly.

Top module: `sburst_ctrl`

## Requirements
- R1: While reset is high and on the first edge after it, the cycle type is deselect (code 0), the address source is none (code 0), the array address is 0, no lane write enable is set and the bus driver enable is low.
- R2: A high sleep input at an edge gives cycle type sleep (code 1) and source none, with all lane write enables low. While sleep is high the bus driver enable is low at once, without waiting for an edge.
- R3: With chip enable 1 (active low) high and the controller strobe low, the cycle is a deselect (code 0, source none), whatever the processor strobe does.
- R4: A strobe that would start a cycle while chip enable 2 (active high) is low or chip enable 3 (active low) is high gives a deselect (code 0, source none).
- R5: A low processor strobe with chip enable 1 low and the device selected gives a burst-start read (code 2, source external code 1), and the array address becomes the external address. The write pins are ignored on that edge.
- R6: A low controller strobe with a high processor strobe and the device selected loads the external address with source external. The cycle is a burst-start write (code 3) when the write qualifier is low and a burst-start read (code 2) when it is high.
- R7: With neither strobe starting a cycle and the advance input low, the cycle is a continue: write (code 5) or read (code 4), as the write qualifier chooses. The source is next (code 2), the two low address bits step by one and wrap from 3 to 0, and the upper bits hold.
- R8: With neither strobe starting a cycle and the advance input high, the cycle is a suspend: write (code 7) or read (code 6). The source is current (code 3) and the array address is unchanged.
- R9: The write qualifier is low when global write is low, or when byte-write enable is low together with at least one lane enable. Lane write enables are raised only on write cycles (codes 3, 5, 7): all lanes when global write is low, otherwise exactly the lanes whose enable is low.
- R10: The bus driver enable is high only during a read cycle (codes 2, 4, 6) while output enable is low and sleep is low. It follows output enable combinationally between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Sleep request, overrides all else |
| ce1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External address |
| cyc_type | output | 3 | Decoded cycle class of the last edge |
| addr_src | output | 2 | Address source of the last edge |
| mem_addr | output | ADDR_W | Array address |
| lane_we | output | LANES | Per-lane array write enables |
| dq_oe | output | 1 | Data-bus output driver enable |

## Verification
The bench builds the block with an 8-bit address and four byte lanes. That leaves six upper address bits whose holding across continue and suspend cycles can be seen, and it lets random addresses land on every low-bit offset, so wraps from 3 to 0 occur often. Four lanes are enough to try single lanes, mixed lane patterns and the all-high pattern that turns the write qualifier off when global write is high. Directed sequences cover the priority corners (processor strobe with chip enable 1 high, strobes with a chip enable inactive, processor strobe with write pins low), and a long run of mixed random inputs covers the rest of the decode table.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_SLEEP    = 3'd1,
        CYC_RD_START = 3'd2,
        CYC_WR_START = 3'd3,
        CYC_RD_CONT  = 3'd4,
        CYC_WR_CONT  = 3'd5,
        CYC_RD_SUSP  = 3'd6,
        CYC_WR_SUSP  = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_NEXT = 2'd2,
        SRC_CUR  = 2'd3
    } src_e;

    typedef struct packed {
        cyc_e cyc;
        src_e src;
    } dec_t;

    // Low means "this cycle writes" (R9).
    function automatic logic wr_qual_n(input logic gw_n, input logic bwe_n,
                                       input logic any_lane_low);
        return gw_n & (bwe_n | ~any_lane_low);
    endfunction

    function automatic logic cyc_is_read(input cyc_e c);
        return (c == CYC_RD_START) || (c == CYC_RD_CONT) || (c == CYC_RD_SUSP);
    endfunction

    function automatic logic cyc_is_write(input cyc_e c);
        return (c == CYC_WR_START) || (c == CYC_WR_CONT) || (c == CYC_WR_SUSP);
    endfunction

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
    import sbc_pkg::*;
(
    input  logic sleep,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic pstb_n,
    input  logic cstb_n,
    input  logic adv_n,
    input  logic wr_n,
    output dec_t dec
);
    logic selected;
    logic pstb_go;

    assign selected = ce2 & ~ce3_n;
    assign pstb_go  = ~pstb_n & ~ce1_n;

    always_comb begin
        dec = '{cyc: CYC_DESEL, src: SRC_NONE};
        if (sleep) begin
            dec = '{cyc: CYC_SLEEP, src: SRC_NONE};
        end else if (ce1_n && !cstb_n) begin
            dec = '{cyc: CYC_DESEL, src: SRC_NONE};
        end else if (pstb_go) begin
            if (selected) dec = '{cyc: CYC_RD_START, src: SRC_EXT};
        end else if (!cstb_n) begin
            if (selected)
                dec = '{cyc: (wr_n ? CYC_RD_START : CYC_WR_START), src: SRC_EXT};
        end else if (!adv_n) begin
            dec = '{cyc: (wr_n ? CYC_RD_CONT : CYC_WR_CONT), src: SRC_NEXT};
        end else begin
            dec = '{cyc: (wr_n ? CYC_RD_SUSP : CYC_WR_SUSP), src: SRC_CUR};
        end
    end
endmodule

// File: rtl/sbc_addr_gen.sv
module sbc_addr_gen
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  src_e              src,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (src)
                SRC_EXT: begin
                    hi_q  <= addr_in[ADDR_W-1:BURST_W];
                    cnt_q <= addr_in[BURST_W-1:0];
                end
                SRC_NEXT: cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_addr = {hi_q, cnt_q};
endmodule

// File: rtl/sbc_lane_we.sv
module sbc_lane_we #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cycle,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lane_we[g] <= 1'b0;
            else     lane_we[g] <= wr_cycle & (~gw_n | (~bwe_n & ~lane_n[g]));
        end
    end
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cyc_type,
    output logic [1:0]        addr_src,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  lane_we,
    output logic              dq_oe
);
    logic wr_n;
    dec_t dec;
    cyc_e cyc_q;
    src_e src_q;

    assign wr_n = wr_qual_n(gw_n, bwe_n, ~&lane_n);

    sbc_decode u_decode (
        .sleep  (sleep),
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .adv_n  (adv_n),
        .wr_n   (wr_n),
        .dec    (dec)
    );

    sbc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .src      (dec.src),
        .addr_in  (addr),
        .mem_addr (mem_addr)
    );

    sbc_lane_we #(.LANES(LANES)) u_we (
        .clk      (clk),
        .rst      (rst),
        .wr_cycle (cyc_is_write(dec.cyc)),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .lane_n   (lane_n),
        .lane_we  (lane_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_DESEL;
            src_q <= SRC_NONE;
        end else begin
            cyc_q <= dec.cyc;
            src_q <= dec.src;
        end
    end

    assign cyc_type = cyc_q;
    assign addr_src = src_q;
    // Output enable and sleep act without the clock; writes mask the drivers.
    assign dq_oe    = cyc_is_read(cyc_q) & ~oe_n & ~sleep;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              pstb_n,
    input logic              cstb_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        cyc_type,
    input logic [1:0]        addr_src,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  lane_we,
    input logic              dq_oe
);
    logic no_start;
    assign no_start = !sleep && cstb_n && (pstb_n || ce1_n);

    a_r2_sleep: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (cyc_type == 3'd1 && addr_src == 2'd0 && lane_we == '0));

    a_r3_ce1_desel: assert property (@(posedge clk) disable iff (rst)
        (!sleep && ce1_n && !cstb_n) |=> (cyc_type == 3'd0 && addr_src == 2'd0));

    a_r4_unselected: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ce1_n && (!pstb_n || !cstb_n) && (!ce2 || ce3_n))
        |=> (cyc_type == 3'd0));

    a_r5_pstb_read: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ce1_n && !pstb_n && ce2 && !ce3_n)
        |=> (cyc_type == 3'd2 && mem_addr == $past(addr)));

    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (no_start && !adv_n) |=> (addr_src == 2'd2 &&
            mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1) &&
            mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (no_start && adv_n) |=> (addr_src == 2'd3 && $stable(mem_addr)));

    a_r9_we_on_write: assert property (@(posedge clk) disable iff (rst)
        (lane_we != '0) |-> (cyc_type == 3'd3 || cyc_type == 3'd5 || cyc_type == 3'd7));

    a_r10_drive: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!oe_n && !sleep && (cyc_type == 3'd2 || cyc_type == 3'd4 || cyc_type == 3'd6)));
endmodule

bind sburst_ctrl sbc_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sbc_checker (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .pstb_n   (pstb_n),
    .cstb_n   (cstb_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .cyc_type (cyc_type),
    .addr_src (addr_src),
    .mem_addr (mem_addr),
    .lane_we  (lane_we),
    .dq_oe    (dq_oe)
);

// File: tb/tb_sburst_ctrl.sv
module tb_sburst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int LANES  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep = 0, ce1_n = 1, ce2 = 0, ce3_n = 1, pstb_n = 1, cstb_n = 1, adv_n = 1;
    logic gw_n = 1, bwe_n = 1, oe_n = 1;
    logic [LANES-1:0]  lane_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic [2:0]        cyc_type;
    logic [1:0]        addr_src;
    logic [ADDR_W-1:0] mem_addr;
    logic [LANES-1:0]  lane_we;
    logic              dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int    e_cyc = 0, e_src = 0, e_hi = 0, e_cnt = 0, e_we = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sburst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .lane_n(lane_n), .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type),
        .addr_src(addr_src), .mem_addr(mem_addr), .lane_we(lane_we), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit is_rd(int c);
        return c == 2 || c == 4 || c == 6;
    endfunction

    // Predict what the edge about to come does with the present inputs.
    task automatic predict();
        bit wq_n, sel;
        wq_n = !(!gw_n || (!bwe_n && lane_n != '1));
        sel  = ce2 && !ce3_n;
        if (sleep) begin
            e_cyc = 1; e_src = 0; e_tag = "R2";
        end else if (ce1_n && !cstb_n) begin
            e_cyc = 0; e_src = 0; e_tag = "R3";
        end else if (!ce1_n && !pstb_n) begin
            if (sel) begin e_cyc = 2; e_src = 1; e_tag = "R5"; end
            else     begin e_cyc = 0; e_src = 0; e_tag = "R4"; end
        end else if (!cstb_n) begin
            if (sel) begin e_cyc = wq_n ? 2 : 3; e_src = 1; e_tag = "R6"; end
            else     begin e_cyc = 0; e_src = 0; e_tag = "R4"; end
        end else if (!adv_n) begin
            e_cyc = wq_n ? 4 : 5; e_src = 2; e_tag = "R7";
        end else begin
            e_cyc = wq_n ? 6 : 7; e_src = 3; e_tag = "R8";
        end
        if (e_src == 1) begin
            e_hi = int'(addr) / 4; e_cnt = int'(addr) % 4;
        end else if (e_src == 2) begin
            e_cnt = (e_cnt + 1) % 4;
        end
        if (e_cyc == 3 || e_cyc == 5 || e_cyc == 7)
            e_we = !gw_n ? 'hF : (bwe_n ? 0 : int'(~lane_n) & 'hF);
        else
            e_we = 0;
    endtask

    task automatic compare();
        check(e_tag, "cyc_type", int'(cyc_type), e_cyc);
        check(e_tag, "addr_src", int'(addr_src), e_src);
        check(e_tag, "mem_addr", int'(mem_addr), e_hi * 4 + e_cnt);
        check("R9", "lane_we", int'(lane_we), e_we);
        check("R10", "dq_oe", int'(dq_oe), int'(is_rd(e_cyc) && !oe_n && !sleep));
    endtask

    // Inputs are already set (at a negedge); run one edge and compare.
    task automatic step();
        predict();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_in(input bit s, c1, c2, c3, p, c, a, g, b, input logic [3:0] ln,
                          input logic [7:0] ad);
        sleep = s; ce1_n = c1; ce2 = c2; ce3_n = c3; pstb_n = p; cstb_n = c; adv_n = a;
        gw_n = g; bwe_n = b; lane_n = ln; addr = ad;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", "cyc_type in reset", int'(cyc_type), 0);
        check("R1", "lane_we in reset", int'(lane_we), 0);
        check("R1", "mem_addr in reset", int'(mem_addr), 0);
        oe_n = 0;
        #1 check("R1", "dq_oe in reset", int'(dq_oe), 0);
        rst = 0;
        // idle suspend after reset: ce1 high, no strobes
        set_in(0,1,0,1, 1,1,1, 1,1,4'hF, 8'h00);
        step();

        // R5: processor strobe, write pins active but ignored
        set_in(0,0,1,0, 0,1,1, 0,0,4'h0, 8'hA6);
        step();
        check("R5", "read start ignores write pins", int'(lane_we), 0);
        // R10: async output enable during read
        oe_n = 1; #1 check("R10", "dq_oe off with oe high", int'(dq_oe), 0);
        oe_n = 0; #1 check("R10", "dq_oe on with oe low", int'(dq_oe), 1);

        // R7: advance with wrap 2->3->0
        set_in(0,1,0,1, 1,1,0, 1,1,4'hF, 8'h00); step();
        step();
        check("R7", "wrapped low bits", int'(mem_addr), 8'hA4);
        // R8: suspend holds
        adv_n = 1; step();

        // R6: controller strobe write, single lane via byte-write
        set_in(0,0,1,0, 1,0,1, 1,0,4'b1011, 8'h3D);
        step();
        check("R9", "single lane write", int'(lane_we), 4'b0100);
        oe_n = 0; #1 check("R10", "writes mask drivers", int'(dq_oe), 0);
        // R6: controller strobe read with all lanes high
        set_in(0,0,1,0, 1,0,1, 1,0,4'hF, 8'h51);
        step();
        // continue write via global write
        set_in(0,1,0,1, 1,1,0, 0,1,4'hF, 8'h00);
        step();
        check("R9", "global write all lanes", int'(lane_we), 4'hF);

        // R3: ce1 high with controller strobe, processor strobe low too
        set_in(0,1,1,0, 0,0,1, 0,1,4'hF, 8'h77); step();
        // R4: unselected via ce2 low and via ce3 high
        set_in(0,0,0,0, 0,1,1, 1,1,4'hF, 8'h12); step();
        set_in(0,0,1,1, 1,0,1, 0,1,4'hF, 8'h12); step();
        // R3 corner: processor strobe with ce1 high and no controller strobe continues
        set_in(0,1,1,0, 0,1,0, 1,1,4'hF, 8'hEE); step();

        // R2: sleep overrides a strobe, drivers off at once
        set_in(0,0,1,0, 0,1,1, 1,1,4'hF, 8'h20); step();
        oe_n = 0; sleep = 1;
        #1 check("R2", "sleep drops drivers at once", int'(dq_oe), 0);
        cstb_n = 0; gw_n = 0; step();

        // random sweep of the whole table
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            set_in(($urandom % 16) == 0, r[0], r[1] | r[2], r[3] & r[4], r[5], r[6], r[7],
                   r[8] | r[9], r[10], 4'($urandom), 8'($urandom));
            oe_n = r[11];
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule